// File: doc/BRIEF.md
# Prescaled Stall Timeout Monitor

This block watches the two halves of a DMA channel, the memory side and the stream side, and raises a sticky flag for a side once that side has been waiting without progress for too long. One programmable prescaler, shared by both sides, divides the clock into a tick. Each side has its own counter. The counter advances on a tick only while its side reports a stall. A progress pulse from that side sends its counter back to zero.

The limit is a 12-bit value. When a side's counter already equals the limit and another tick arrives, that side's timeout flag rises and stays high. The all-ones limit code is not a limit at all. While it is applied, both counters and both flags are cleared. A single enable governs both sides. Lowering it clears everything, and raising it again starts the prescaler from zero.

Top module: `stall_timeout_monitor`

## Requirements
- R1: While `rst` is high, and at the first sampling point after it falls, both timeout flags are 0.
- R2: With prescaler value N, the prescaler ticks once every N+1 enabled clock cycles. 0 ticks every cycle and 0xFFF ticks every 4096 cycles. The first tick after enable rises comes at the (N+1)th clock edge.
- R3: For a limit L from 0x000 to 0xFFE, with the side stalled and no progress from the moment enable rises, the flag goes high after exactly (L+1)*(N+1) clock edges and not one edge earlier.
- R4: A limit of 0xFFF clears both counters and both flags at the next edge. While it is held, no flag rises. After a new limit L is applied, a stalled side needs the full L+1 ticks.
- R5: With `enable` low, both counters and both flags are cleared at the next edge. When enable rises again, the prescaler restarts from zero, so no partly elapsed tick period carries over.
- R6: A progress pulse on a side resets that side's counter to zero at that edge. The other side is unaffected.
- R7: While a side's stall input is low, its counter stays at zero. A side that becomes stalled later needs the full L+1 ticks.
- R8: A raised flag stays high through progress pulses and idle periods. Only the 0xFFF limit or a low enable clears it.
- R9: The two sides count and flag independently, and both share the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Enables both counters; low clears them |
| presc_val | input | 12 | Prescaler value N (tick every N+1 cycles) |
| limit_val | input | 12 | Timeout limit; 0xFFF means clear both |
| mem_stall | input | 1 | Memory side is waiting |
| mem_progress | input | 1 | Memory side made progress (pulse) |
| strm_stall | input | 1 | Stream side is waiting |
| strm_progress | input | 1 | Stream side made progress (pulse) |
| mem_timeout | output | 1 | Sticky memory-side timeout flag |
| strm_timeout | output | 1 | Sticky stream-side timeout flag |

## Verification
The tick is combinational from the prescaler register, and each flag is a register behind it. A flag therefore rises on the edge of its (L+1)th tick, which is clock edge (L+1)*(N+1) counted from the edge on which enable is first seen high. Clears through 0xFFF or a low enable show on the very next edge. The bench drives and samples on falling edges. For each timed result it checks once at the edge just before the expected one, expecting 0, and once at the expected edge, expecting 1, so an off-by-one in the prescaler or the compare is caught in either direction.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    localparam int PRESC_W   = 12;
    localparam int LIM_W     = 12;
    localparam int NUM_SIDES = 2;

    // side identifiers; the value is the index into the per-side arrays
    typedef enum logic [0:0] {
        SIDE_MEM  = 1'b0,
        SIDE_STRM = 1'b1
    } side_e;

    // what one side reports each cycle
    typedef struct packed {
        logic stall;
        logic progress;
    } side_in_t;

    // next action of a side counter
    typedef enum logic [1:0] {
        ACT_CLEAR   = 2'd0,
        ACT_RESTART = 2'd1,
        ACT_ADVANCE = 2'd2,
        ACT_HOLD    = 2'd3
    } cnt_act_e;

    // all-ones limit is a clear command rather than a limit
    function automatic logic is_clear_cmd(input logic [LIM_W-1:0] v);
        return &v;
    endfunction

endpackage

// File: rtl/tmo_tick_gen.sv
module tmo_tick_gen
    import tmo_pkg::*;
#(
    parameter int W = PRESC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic [W-1:0] presc,
    output logic         tick
);

    logic [W-1:0] cnt;

    // >= keeps a lowered prescaler value from forcing a long wrap
    assign tick = enable && (cnt >= presc);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_no_tick_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !tick);

    p_restart_on_enable_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(enable) |-> (cnt == '0));

    p_wrap_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

    p_step_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        (enable && !tick) |=> (!enable || (cnt == $past(cnt) + 1'b1)));

endmodule

// File: rtl/tmo_side_counter.sv
module tmo_side_counter
    import tmo_pkg::*;
#(
    parameter int W = LIM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         tick,
    input  side_in_t     side_i,
    input  logic [W-1:0] limit,
    output logic         flag
);

    logic [W-1:0] count;
    cnt_act_e     act;
    logic         at_limit;

    assign at_limit = (count == limit);

    always_comb begin
        if (clear) begin
            act = ACT_CLEAR;
        end else if (side_i.progress || !side_i.stall) begin
            act = ACT_RESTART;
        end else if (tick) begin
            act = ACT_ADVANCE;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            flag  <= 1'b0;
        end else begin
            unique case (act)
                ACT_CLEAR: begin
                    count <= '0;
                    flag  <= 1'b0;
                end
                ACT_RESTART: begin
                    count <= '0;
                end
                ACT_ADVANCE: begin
                    if (at_limit) begin
                        flag <= 1'b1;
                    end else begin
                        count <= count + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clear) |=> flag);

    p_clear_drops_r4: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!flag && (count == '0)));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (!clear && !side_i.stall) |=> (count == '0));

    p_progress_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!clear && side_i.progress) |=> (count == '0));

    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (!clear && side_i.stall && !side_i.progress && tick && (count != limit))
        |=> (count == $past(count) + 1'b1));

    p_hit_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (!clear && side_i.stall && !side_i.progress && tick && (count == limit))
        |=> flag);

    p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!clear && side_i.stall && !side_i.progress && !tick) |=> $stable(count));

endmodule

// File: rtl/stall_timeout_monitor.sv
module stall_timeout_monitor
    import tmo_pkg::*;
#(
    parameter int PW = PRESC_W,
    parameter int LW = LIM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [PW-1:0] presc_val,
    input  logic [LW-1:0] limit_val,
    input  logic          mem_stall,
    input  logic          mem_progress,
    input  logic          strm_stall,
    input  logic          strm_progress,
    output logic          mem_timeout,
    output logic          strm_timeout
);

    localparam int MEM_IDX  = int'(SIDE_MEM);
    localparam int STRM_IDX = int'(SIDE_STRM);

    logic                 tick;
    logic                 clear_all;
    side_in_t             side_in  [NUM_SIDES];
    logic [NUM_SIDES-1:0] flag_vec;

    assign clear_all = !enable || (&limit_val);

    assign side_in[MEM_IDX]  = '{stall: mem_stall,  progress: mem_progress};
    assign side_in[STRM_IDX] = '{stall: strm_stall, progress: strm_progress};

    tmo_tick_gen #(.W(PW)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .presc  (presc_val),
        .tick   (tick)
    );

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        tmo_side_counter #(.W(LW)) u_side (
            .clk    (clk),
            .rst    (rst),
            .clear  (clear_all),
            .tick   (tick),
            .side_i (side_in[g]),
            .limit  (limit_val),
            .flag   (flag_vec[g])
        );
    end

    assign mem_timeout  = flag_vec[MEM_IDX];
    assign strm_timeout = flag_vec[STRM_IDX];

    p_both_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (enable && (&limit_val)) |=> (flag_vec == '0));

    p_disable_clears_r5: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (flag_vec == '0));

    p_reset_flags_r1: assert property (@(posedge clk)
        rst |=> (flag_vec == '0));

endmodule

// File: tb/sim_stall_timeout_monitor.sv
module sim_stall_timeout_monitor;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [11:0] presc_val;
    logic [11:0] limit_val;
    logic        mem_stall, mem_progress, strm_stall, strm_progress;
    logic        mem_timeout, strm_timeout;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    stall_timeout_monitor u0 (
        .clk(clk), .rst(rst), .enable(enable),
        .presc_val(presc_val), .limit_val(limit_val),
        .mem_stall(mem_stall), .mem_progress(mem_progress),
        .strm_stall(strm_stall), .strm_progress(strm_progress),
        .mem_timeout(mem_timeout), .strm_timeout(strm_timeout)
    );

    localparam int NV = 6;
    localparam logic [11:0] V_PRESC [NV] = '{12'h000, 12'h000, 12'h003, 12'h000, 12'h007, 12'hFFF};
    localparam logic [11:0] V_LIM   [NV] = '{12'h000, 12'h005, 12'h002, 12'hFFE, 12'h00A, 12'h000};

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // advance n rising edges, land on the following falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // drop enable for one edge, then raise it at a falling edge
    task automatic restart();
        enable = 1'b0;
        step(1);
        enable = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b1; presc_val = '0; limit_val = '0;
        mem_stall = 1'b1; strm_stall = 1'b1; mem_progress = 1'b0; strm_progress = 1'b0;
        @(negedge clk);
        step(3);
        check("R1 mem in reset", mem_timeout, 1'b0);
        check("R1 strm in reset", strm_timeout, 1'b0);
        enable = 1'b0;
        rst = 1'b0;
        check("R1 mem after reset", mem_timeout, 1'b0);
        check("R1 strm after reset", strm_timeout, 1'b0);

        // table: flag due at edge (L+1)*(N+1) after enable rises (R2, R3, R9)
        for (int i = 0; i < NV; i++) begin
            int t;
            presc_val = V_PRESC[i];
            limit_val = V_LIM[i];
            mem_stall = 1'b1; strm_stall = 1'b1;
            t = (int'(V_LIM[i]) + 1) * (int'(V_PRESC[i]) + 1);
            restart();
            if (t > 1) begin
                step(t - 1);
                check("R3 mem early", mem_timeout, 1'b0);
                check("R2 strm early", strm_timeout, 1'b0);
                step(1);
            end else begin
                step(1);
            end
            check("R3 mem due", mem_timeout, 1'b1);
            check("R9 strm due", strm_timeout, 1'b1);
        end

        // R6: progress restarts the memory count; stream side unaffected
        presc_val = 12'h000; limit_val = 12'h005;
        mem_stall = 1'b1; strm_stall = 1'b1;
        restart();
        step(4);
        mem_progress = 1'b1;
        step(1);
        mem_progress = 1'b0;
        step(1);
        check("R9 strm unaffected by mem progress", strm_timeout, 1'b1);
        check("R6 mem restarted", mem_timeout, 1'b0);
        step(4);
        check("R6 mem before full window", mem_timeout, 1'b0);
        step(1);
        check("R6 mem after full window", mem_timeout, 1'b1);

        // R8: sticky through progress and idle
        mem_progress = 1'b1;
        mem_stall = 1'b0;
        step(1);
        mem_progress = 1'b0;
        step(5);
        check("R8 mem sticky", mem_timeout, 1'b1);
        mem_stall = 1'b1;

        // R4: 0xFFF clears both and holds them clear
        limit_val = 12'hFFF;
        step(1);
        check("R4 mem cleared", mem_timeout, 1'b0);
        check("R4 strm cleared", strm_timeout, 1'b0);
        step(50);
        check("R4 mem held clear", mem_timeout, 1'b0);
        check("R4 strm held clear", strm_timeout, 1'b0);
        limit_val = 12'h002;
        step(2);
        check("R4 mem count restarted", mem_timeout, 1'b0);
        step(1);
        check("R4 mem after new limit", mem_timeout, 1'b1);

        // R5: disable clears; prescaler restarts on enable rise
        enable = 1'b0;
        step(1);
        check("R5 mem disabled", mem_timeout, 1'b0);
        check("R5 strm disabled", strm_timeout, 1'b0);
        presc_val = 12'h003; limit_val = 12'h000;
        enable = 1'b1;
        step(2);
        enable = 1'b0;
        step(1);
        enable = 1'b1;
        step(3);
        check("R5 prescaler restarted", mem_timeout, 1'b0);
        step(1);
        check("R5 first tick after restart", mem_timeout, 1'b1);

        // R7: idle side stays at zero while the other side times out
        presc_val = 12'h000; limit_val = 12'h003;
        mem_stall = 1'b0; strm_stall = 1'b1;
        restart();
        step(10);
        check("R7 idle mem no flag", mem_timeout, 1'b0);
        check("R9 strm flag", strm_timeout, 1'b1);
        mem_stall = 1'b1;
        step(3);
        check("R7 mem starts from zero", mem_timeout, 1'b0);
        step(1);
        check("R7 mem after full window", mem_timeout, 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule